// File: doc/BRIEF.md
# Machine-Check Condition Collector

This block sits beside a processor core and gathers the error reports that its units raise. Damage and recovery reports arrive as single-cycle strobes and are held as pending conditions. A few inputs are treated differently. The imminent-failure warning is a live level. Clock faults are detected on a rising edge. CPU-timer and comparator damage count only while the matching external interrupt is enabled. From the pending set, the block raises a machine-check interruption request and says whether the request is exigent or repressible.

Exigent conditions (system damage and instruction-processing damage) always raise the request. Repressible conditions raise it only when their subclass mask bit is one. When the core acknowledges a raised request, the block builds a 64-bit interruption code from the state just before the acknowledge edge and presents it for one cycle. It then clears the conditions it reported.

Repeated system-recovery events are counted. Once their number exceeds a build-time threshold, they are escalated to a degradation condition.

Top module: `mchk_collector`

## Requirements
- R1: After reset, `irq_req`, `irq_exigent` and `code_vld` are 0, `code_out` is all zeros, no condition is pending and the recovery-event count is zero.
- R2: Code bit k appears on `code_out[k]`. The assignments are:
  - bit 0: system damage; bit 1: instruction-processing damage; bit 2: system recovery;
  - bit 3: interval-timer damage; bit 4: timing-facility damage; bit 5: external damage;
  - bit 7: degradation; bit 8: warning; bit 15: `delayed_in` as sampled at the acknowledge;
  - bit 16: uncorrected storage error; bit 18: uncorrected storage-key error;
  - bits 20 to 24 take `vld_flags[4:0]`, bits 27 to 29 take `vld_flags[7:5]`, bit 31 takes `vld_flags[8]`, and bits 47:46 take `vld_flags[10:9]`.
  - Every other bit is zero.
- R3: A pending system damage or instruction-processing damage drives `irq_req` and `irq_exigent` to 1, whatever the value of `sub_mask`.
- R4: `sub_mask` bits enable the repressible conditions as follows: [0] recovery, [1] interval timer, [2] timing facility, [3] external damage, [4] degradation, [5] warning. A condition whose mask bit is 0 does not raise `irq_req` and is not reported, but it stays pending and raises the request once its bit is set.
- R5: An `ack` is taken only while `irq_req` is 1. The code is then captured from the state in the cycle of the acknowledge. `code_vld` is 1 in the following cycle only, and the code always has at least one of bits 0 to 5, 7 or 8 set. An `ack` while `irq_req` is 0 is ignored.
- R6: A taken acknowledge clears every latched condition it reported, and the storage and storage-key error bits. Masked conditions stay pending. A strobe arriving in the same cycle as the acknowledge stays pending.
- R7: The warning condition follows `warn_lvl` directly. If the level drops before acknowledge, the request drops with it. An acknowledge does not clear it, so a persisting warning gives repeated interruptions.
- R8: Each `recov_stb` sets system recovery and counts one event. The event that takes the count above RECOV_LIMIT sets degradation. The count saturates at RECOV_LIMIT+1, and it returns to zero when an acknowledge reports degradation.
- R9: Timing-facility damage is set on a rising edge of `tod_fault`, always. It is set by `cput_dmg` only while `cput_ie` is 1, and by `ccmp_dmg` only while `ccmp_ie` is 1. Once pending, it stays pending when the enable drops.
- R10: When system damage is reported, all validity bits of the code (bits 20 to 24, 27 to 29, 31, 46 and 47) are zero, whatever `vld_flags` holds.
- R11: `stor_err_stb` and `key_err_stb` latch their errors. The latched errors are reported in the next code regardless of mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysdmg_stb | input | 1 | System damage report |
| procdmg_stb | input | 1 | Instruction-processing damage report |
| recov_stb | input | 1 | Recovered-malfunction event |
| itmr_stb | input | 1 | Interval-timer damage report |
| extdmg_stb | input | 1 | External damage report |
| stor_err_stb | input | 1 | Uncorrected storage error |
| key_err_stb | input | 1 | Uncorrected storage-key error |
| warn_lvl | input | 1 | Imminent-damage warning level |
| tod_fault | input | 1 | Time-of-day clock in error or not operational |
| cput_dmg | input | 1 | CPU timer damaged |
| cput_ie | input | 1 | CPU-timer external interrupt enabled |
| ccmp_dmg | input | 1 | Clock comparator damaged |
| ccmp_ie | input | 1 | Comparator external interrupt enabled |
| sub_mask | input | 6 | Repressible subclass enables |
| delayed_in | input | 1 | Delayed-report flag for the code |
| vld_flags | input | 11 | Saved-state validity flags |
| ack | input | 1 | Interruption acknowledge |
| irq_req | output | 1 | Machine-check interruption request |
| irq_exigent | output | 1 | Request is exigent |
| code_vld | output | 1 | Code valid, one cycle |
| code_out | output | 64 | Interruption code |

## Verification
The bench builds the block with RECOV_LIMIT set to 3. With that value, the escalation to degradation, the saturation of the event counter and its reset on report are all reached within a few dozen strobes. Directed sequences cover:
- the masked, exigent, warning and timing-enable cases;
- an acknowledge that meets a fresh strobe in the same cycle.

A long random run with sparse strobes, changing masks and frequent acknowledges then mixes overlapping conditions. A behavioural model checks every cycle of this run.

// File: rtl/mchk_collector.sv
module mchk_collector #(
  parameter int RECOV_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sysdmg_stb,
  input  logic        procdmg_stb,
  input  logic        recov_stb,
  input  logic        itmr_stb,
  input  logic        extdmg_stb,
  input  logic        stor_err_stb,
  input  logic        key_err_stb,
  input  logic        warn_lvl,
  input  logic        tod_fault,
  input  logic        cput_dmg,
  input  logic        cput_ie,
  input  logic        ccmp_dmg,
  input  logic        ccmp_ie,
  input  logic [5:0]  sub_mask,
  input  logic        delayed_in,
  input  logic [10:0] vld_flags,
  input  logic        ack,
  output logic        irq_req,
  output logic        irq_exigent,
  output logic        code_vld,
  output logic [63:0] code_out
);
  localparam int CW = $clog2(RECOV_LIMIT + 2);
  localparam logic [CW-1:0] LIM_V = CW'(RECOV_LIMIT);
  localparam logic [CW-1:0] TOP_V = CW'(RECOV_LIMIT + 1);

  logic sd_q, pd_q, sr_q, td_q, cd_q, ed_q, dg_q, se_q, ke_q, tod_q;
  logic [CW-1:0] cnt_q, cnt_base, cnt_d;
  logic [5:0] rep_pend, rep_live;
  logic [10:0] vbits;
  logic [63:0] code_d;
  logic take, cd_set, dg_set;

  assign rep_pend    = {warn_lvl, dg_q, ed_q, cd_q, td_q, sr_q};
  assign rep_live    = rep_pend & sub_mask;
  assign irq_exigent = sd_q | pd_q;
  assign irq_req     = irq_exigent | (|rep_live);
  assign take        = ack & irq_req;
  assign cd_set      = (tod_fault & ~tod_q) | (cput_dmg & cput_ie) | (ccmp_dmg & ccmp_ie);

  assign cnt_base = (take && rep_live[4]) ? '0 : cnt_q;
  assign dg_set   = recov_stb && (cnt_base >= LIM_V);
  assign cnt_d    = (recov_stb && cnt_base != TOP_V) ? cnt_base + 1'b1 : cnt_base;

  assign vbits = sd_q ? '0 : vld_flags;

  always_comb begin
    code_d        = '0;
    code_d[0]     = sd_q;
    code_d[1]     = pd_q;
    code_d[5:2]   = rep_live[3:0];
    code_d[7]     = rep_live[4];
    code_d[8]     = rep_live[5];
    code_d[15]    = delayed_in;
    code_d[16]    = se_q;
    code_d[18]    = ke_q;
    code_d[24:20] = vbits[4:0];
    code_d[29:27] = vbits[7:5];
    code_d[31]    = vbits[8];
    code_d[47:46] = vbits[10:9];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sd_q, pd_q, sr_q, td_q, cd_q, ed_q, dg_q, se_q, ke_q, tod_q} <= '0;
      cnt_q    <= '0;
      code_vld <= 1'b0;
      code_out <= '0;
    end else begin
      sd_q  <= (sd_q & ~take) | sysdmg_stb;
      pd_q  <= (pd_q & ~take) | procdmg_stb;
      se_q  <= (se_q & ~take) | stor_err_stb;
      ke_q  <= (ke_q & ~take) | key_err_stb;
      sr_q  <= (sr_q & ~(take & sub_mask[0])) | recov_stb;
      td_q  <= (td_q & ~(take & sub_mask[1])) | itmr_stb;
      cd_q  <= (cd_q & ~(take & sub_mask[2])) | cd_set;
      ed_q  <= (ed_q & ~(take & sub_mask[3])) | extdmg_stb;
      dg_q  <= (dg_q & ~(take & sub_mask[4])) | dg_set;
      tod_q <= tod_fault;
      cnt_q <= cnt_d;
      code_vld <= take;
      if (take) code_out <= code_d;
    end
  end
endmodule

module mchk_collector_chk #(
  parameter int RECOV_LIMIT = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ack,
  input logic        warn_lvl,
  input logic [5:0]  sub_mask,
  input logic        irq_req,
  input logic        irq_exigent,
  input logic        code_vld,
  input logic [63:0] code_out,
  input logic [31:0] cnt
);
  localparam logic [63:0] ASSIGNED = 64'h0000_C000_B9F5_81BF;
  localparam logic [63:0] VALIDITY = 64'h0000_C000_B9F0_0000;

  assert_exigent_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_exigent |-> irq_req);
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> code_vld);
  assert_ignored_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq_req) |=> !code_vld);
  assert_subclass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> (code_out[8:7] != 2'b00 || code_out[5:0] != 6'd0));
  assert_unassigned_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> ((code_out & ~ASSIGNED) == 64'd0));
  assert_validity_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && code_out[0]) |-> ((code_out & VALIDITY) == 64'd0));
  assert_warn_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && warn_lvl && sub_mask[5]) |=> code_out[8]);
  assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 32'(RECOV_LIMIT + 1));
endmodule

bind mchk_collector mchk_collector_chk #(.RECOV_LIMIT(RECOV_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .warn_lvl(warn_lvl), .sub_mask(sub_mask),
  .irq_req(irq_req), .irq_exigent(irq_exigent), .code_vld(code_vld),
  .code_out(code_out), .cnt(32'(cnt_q))
);

// File: tb/tb_mchk_collector.sv
module tb_mchk_collector;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 3;

  logic clk = 0, rst_n = 0;
  logic sysdmg_stb = 0, procdmg_stb = 0, recov_stb = 0, itmr_stb = 0, extdmg_stb = 0;
  logic stor_err_stb = 0, key_err_stb = 0, warn_lvl = 0, tod_fault = 0;
  logic cput_dmg = 0, cput_ie = 0, ccmp_dmg = 0, ccmp_ie = 0;
  logic [5:0] sub_mask = 0;
  logic delayed_in = 0;
  logic [10:0] vld_flags = 0;
  logic ack = 0;
  logic irq_req, irq_exigent, code_vld;
  logic [63:0] code_out;

  mchk_collector #(.RECOV_LIMIT(LIM)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit m_sd, m_pd, m_sr, m_td, m_cd, m_ed, m_dg, m_se, m_ke, m_tod, m_vld;
  int m_cnt;
  logic [63:0] m_code;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] m_live();
    return {warn_lvl, m_dg, m_ed, m_cd, m_td, m_sr} & sub_mask;
  endfunction

  function automatic logic m_req();
    return m_sd | m_pd | (|m_live());
  endfunction

  task automatic model_update();
    logic [5:0] lv = m_live();
    bit tk = ack && m_req();
    logic [10:0] v = m_sd ? 11'd0 : vld_flags;
    m_vld = tk;
    if (tk) begin
      m_code = 0;
      m_code[0] = m_sd; m_code[1] = m_pd; m_code[2] = lv[0]; m_code[3] = lv[1];
      m_code[4] = lv[2]; m_code[5] = lv[3]; m_code[7] = lv[4]; m_code[8] = lv[5];
      m_code[15] = delayed_in; m_code[16] = m_se; m_code[18] = m_ke;
      for (int i = 0; i < 5; i++) m_code[20+i] = v[i];
      for (int i = 0; i < 3; i++) m_code[27+i] = v[5+i];
      m_code[31] = v[8]; m_code[46] = v[9]; m_code[47] = v[10];
      m_sd = 0; m_pd = 0; m_se = 0; m_ke = 0;
      if (lv[0]) m_sr = 0;
      if (lv[1]) m_td = 0;
      if (lv[2]) m_cd = 0;
      if (lv[3]) m_ed = 0;
      if (lv[4]) begin m_dg = 0; m_cnt = 0; end
    end
    if (recov_stb) begin
      m_sr = 1;
      if (m_cnt >= LIM) m_dg = 1;
      if (m_cnt < LIM + 1) m_cnt++;
    end
    if (sysdmg_stb) m_sd = 1;
    if (procdmg_stb) m_pd = 1;
    if (itmr_stb) m_td = 1;
    if (extdmg_stb) m_ed = 1;
    if (stor_err_stb) m_se = 1;
    if (key_err_stb) m_ke = 1;
    if ((tod_fault && !m_tod) || (cput_dmg && cput_ie) || (ccmp_dmg && ccmp_ie)) m_cd = 1;
    m_tod = tod_fault;
  endtask

  task automatic step(string tag);
    #1;
    chk({tag, " req"}, 64'(irq_req), 64'(m_req()));
    chk({tag, " exigent"}, 64'(irq_exigent), 64'(m_sd | m_pd));
    chk({tag, " code_vld"}, 64'(code_vld), 64'(m_vld));
    if (m_vld) chk({tag, " code"}, code_out, m_code);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic quiet();
    {sysdmg_stb, procdmg_stb, recov_stb, itmr_stb, extdmg_stb, stor_err_stb, key_err_stb, ack} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset req", 64'(irq_req), 0);
    chk("R1 reset vld", 64'(code_vld), 0);
    chk("R1 reset code", code_out, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 masked repressible, R3 exigent, R10 validity forced off
    itmr_stb = 1; step("R4 mask");
    quiet(); #1 chk("R4 masked td no req", 64'(irq_req), 0);
    sysdmg_stb = 1; step("R3 sd");
    quiet(); #1 chk("R3 exigent req", 64'({irq_req, irq_exigent}), 64'b11);
    vld_flags = '1; delayed_in = 1; ack = 1; step("R5 ack");
    quiet(); delayed_in = 0;
    #1 chk("R10 sd code", code_out, 64'h8001);
    chk("R5 code_vld", 64'(code_vld), 1);
    chk("R6 cleared", 64'(irq_req), 0);
    sub_mask = 6'b000010; #1 chk("R4 retained td", 64'(irq_req), 1);
    ack = 1; step("R2 td ack");
    quiet(); #1 chk("R2 layout", code_out, 64'h0000_C000_B9F0_0008);
    vld_flags = 0;

    // R7 warning follows level
    sub_mask = 6'b100000; warn_lvl = 1; #1 chk("R7 warn live", 64'(irq_req), 1);
    warn_lvl = 0; #1 chk("R7 warn dropped", 64'(irq_req), 0);
    step("R7 idle");
    warn_lvl = 1; ack = 1; step("R7 ack1");
    quiet(); #1 chk("R7 code", code_out, 64'h100);
    chk("R7 still req", 64'(irq_req), 1);
    ack = 1; step("R7 ack2");
    quiet(); #1 chk("R7 repeat vld", 64'(code_vld), 1);
    warn_lvl = 0; step("R7 off");

    // R9 timing facility
    sub_mask = 6'b000100; cput_dmg = 1; step("R9 dis");
    #1 chk("R9 disabled ignored", 64'(irq_req), 0);
    cput_ie = 1; step("R9 en");
    cput_dmg = 0; cput_ie = 0; #1 chk("R9 pending kept", 64'(irq_req), 1);
    ack = 1; step("R9 ack"); quiet();
    tod_fault = 1; step("R9 tod");
    #1 chk("R9 tod edge", 64'(irq_req), 1);
    ack = 1; step("R9 tod ack"); quiet();
    step("R9 tod held");
    #1 chk("R9 tod level no reset", 64'(irq_req), 0);
    tod_fault = 0; step("R9 tod low");

    // R5 ignored ack
    sub_mask = 0; ack = 1; step("R5 ign"); quiet();
    #1 chk("R5 ack ignored", 64'(code_vld), 0);

    // R6 same-cycle strobe retained, R11 storage errors
    sysdmg_stb = 1; stor_err_stb = 1; step("R6 s1");
    ack = 1; sysdmg_stb = 1; stor_err_stb = 0; step("R6 s2"); quiet();
    #1 chk("R11 storage err code", code_out, 64'h1_0001);
    chk("R6 retained", 64'(irq_exigent), 1);
    ack = 1; step("R6 s3"); quiet();
    #1 chk("R6 cleared", 64'(irq_req), 0);

    // R8 degradation
    sub_mask = 6'b010000;
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < LIM; i++) begin recov_stb = 1; step("R8 rec"); end
      quiet(); #1 chk("R8 below limit", 64'(irq_req), 0);
      recov_stb = 1; step("R8 over"); quiet();
      #1 chk("R8 degradation", 64'(irq_req), 1);
      ack = 1; step("R8 ack"); quiet();
      #1 chk("R8 code", code_out, 64'h80);
    end

    // random mix checked against the model
    for (int c = 0; c < 4000; c++) begin
      sysdmg_stb   = ($urandom % 64) == 0;
      procdmg_stb  = ($urandom % 48) == 0;
      recov_stb    = ($urandom % 4) == 0;
      itmr_stb     = ($urandom % 32) == 0;
      extdmg_stb   = ($urandom % 32) == 0;
      stor_err_stb = ($urandom % 40) == 0;
      key_err_stb  = ($urandom % 40) == 0;
      if ($urandom % 16 == 0) warn_lvl = ~warn_lvl;
      if ($urandom % 20 == 0) tod_fault = ~tod_fault;
      cput_dmg = ($urandom % 24) == 0; ccmp_dmg = ($urandom % 24) == 0;
      if ($urandom % 10 == 0) begin cput_ie = $urandom; ccmp_ie = $urandom; end
      if ($urandom % 12 == 0) sub_mask = 6'($urandom);
      delayed_in = $urandom; vld_flags = 11'($urandom);
      ack = ($urandom % 3) == 0;
      step("R2 R4 R5 R6 R8 R9 R11 random");
    end
    quiet(); step("end");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule